// File: doc/BRIEF.md
# Display Frame Serializer

This block is the host-side transmitter for a self-latching serial display receiver. A request captures a 34-bit parallel image on its own clock edge. The image holds three digit fields of eight bits each and ten auxiliary output bits. The block then drives three lines to the display: an active-low enable, a serial clock and a serial data line. The receiver latches the frame when the leading start bit reaches the end of its shift register, so the frame is not a whole number of bytes.

There are two frame formats, chosen per frame by a mode input.

- **Exact mode** sends 36 bits: the start bit, the 34 payload bits and one latch clock with data low.
- **Padded mode** sends 40 bits as five whole bytes, one byte after another, the way a byte-oriented shift engine would. The start bit is the most significant bit of the first byte. Each digit's decimal point moves into the following byte. Every bit after the payload is zero.

Counters set the enable setup time, the clock high and low widths, and the refresh gap after the frame. A controller state machine drives these timings through five named states:

- `ST_IDLE`: waiting for a request.
- `ST_SETUP`: enable low, no clock.
- `ST_LOW`: clock low, bit presented.
- `ST_HIGH`: clock high.
- `ST_GAP`: enable high, refresh wait.

The transitions are:

- start: `ST_IDLE`→`ST_SETUP`
- setup done: `ST_SETUP`→`ST_LOW`
- half period done: `ST_LOW`→`ST_HIGH`
- bit advance: `ST_HIGH`→`ST_LOW`
- last bit done: `ST_HIGH`→`ST_GAP`
- gap done: `ST_GAP`→`ST_IDLE`

Top module: `dfs_top`

## Requirements
- R1: After reset the outputs are: `disp_en_n` high, `ser_clk` low, `ser_dat` low and `busy` low.
- R2: With `mode` = 0 (exact), a frame has exactly 36 rising edges of `ser_clk`. The bits sampled at those edges are, in order: a 1, then `image[0]` through `image[33]`, then a 0 that latches the frame.
- R3: With `mode` = 1 (padded), a frame has exactly 40 rising edges of `ser_clk`. The bits are, in order: a 1, then `image[0]` through `image[33]`, then five zeros.
- R4: The image layout is fixed. `image[7:0]`, `image[15:8]` and `image[23:16]` are digits 1, 2 and 3, each with bit 0 = segment a up to bit 7 = decimal point. `image[33:24]` are the output bits. Bits go out least significant first, so in padded mode byte 0 is the start bit followed by `image[6:0]`, and byte 1 begins with `image[7]`.
- R5: `disp_en_n` falls at least `SETUP_CYC` clock cycles before the first rising edge of `ser_clk`. It stays low until after the last falling edge of `ser_clk`.
- R6: `ser_clk` is low whenever `disp_en_n` is high. Inside a frame, each high phase of `ser_clk` lasts exactly `DIV` cycles and each low phase lasts at least `DIV` cycles.
- R7: `ser_dat` changes only while `ser_clk` is low. The value one cycle before a rising edge equals the value sampled at that edge.
- R8: `busy` rises in the cycle after an accepted `start` strobe. After the frame, `disp_en_n` stays high with `busy` still high for exactly `GAP_CYC` cycles, and then `busy` falls.
- R9: A `start` strobe while `busy` is high is ignored. The frame in progress is unchanged and no second frame follows it.
- R10: `ser_dat` is low whenever `disp_en_n` is high.
- R11: In padded mode a new byte is loaded only after all eight bits of the previous byte have been clocked out.
- R12: The image and mode are captured on the accepted strobe. Changing `image` or `mode` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send a frame |
| mode | input | 1 | 0 = exact 36-bit frame, 1 = padded 40-bit frame |
| image | input | 34 | Parallel display image |
| busy | output | 1 | High from an accepted request to the end of the refresh gap |
| disp_en_n | output | 1 | Active-low display data enable |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_dat | output | 1 | Serial data, sampled on the rising clock edge |

## Verification
The two functions that can fall in the same cycle are the acceptance of a new request and the bit advance of a frame already running. The same holds for a request landing on a clock edge or on a padded-mode byte boundary. The bench provokes this by pulsing `start` at random offsets inside a running frame, with a different image and mode on the inputs. It judges the result by checking that the captured bit stream still matches the first image in both content and length, and that the enable line stays high after the gap.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } dfs_state_e;

    typedef enum logic {
        MODE_EXACT  = 1'b0,
        MODE_PADDED = 1'b1
    } dfs_mode_e;

    function automatic int dfs_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dfs_frame_build.sv
module dfs_frame_build #(
    parameter int PAY_W    = 34,
    parameter int FRAME_W  = 40
) (
    input  logic [PAY_W-1:0]   image_i,
    output logic [FRAME_W-1:0] frame_o
);
    // Stream order is MSB first: start bit, then image[0] .. image[PAY_W-1], then zeros.
    localparam int PAD_W = FRAME_W - PAY_W - 1;

    assign frame_o[FRAME_W-1] = 1'b1;

    for (genvar i = 0; i < PAY_W; i++) begin : g_pay
        assign frame_o[FRAME_W-2-i] = image_i[i];
    end

    for (genvar j = 0; j < PAD_W; j++) begin : g_pad
        assign frame_o[j] = 1'b0;
    end

endmodule

// File: rtl/dfs_byte_shifter.sv
module dfs_byte_shifter #(
    parameter int FRAME_BYTES = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_i,
    input  logic                     adv_i,
    input  logic [FRAME_BYTES*8-1:0] frame_i,
    output logic                     bit_o
);
    localparam int FW = FRAME_BYTES * 8;
    localparam int IW = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;

    logic [FW-1:0] frame_q;
    logic [7:0]    bytes [FRAME_BYTES];
    logic [7:0]    byte_q;
    logic [2:0]    bit_idx_q;
    logic [IW-1:0] byte_idx_q;
    logic [IW-1:0] byte_nxt;
    logic          last_byte;

    // Slice the held frame into whole bytes, byte 0 first on the wire.
    for (genvar k = 0; k < FRAME_BYTES; k++) begin : g_bytes
        assign bytes[k] = frame_q[FW-1-8*k -: 8];
    end

    assign last_byte = (byte_idx_q == IW'(FRAME_BYTES-1));
    assign byte_nxt  = last_byte ? byte_idx_q : byte_idx_q + IW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q    <= '0;
            byte_q     <= '0;
            bit_idx_q  <= '0;
            byte_idx_q <= '0;
        end else if (cap_i) begin
            frame_q    <= frame_i;
            byte_q     <= frame_i[FW-1 -: 8];
            bit_idx_q  <= '0;
            byte_idx_q <= '0;
        end else if (adv_i) begin
            if (bit_idx_q == 3'd7) begin
                byte_q     <= last_byte ? 8'h00 : bytes[byte_nxt];
                byte_idx_q <= byte_nxt;
                bit_idx_q  <= '0;
            end else begin
                byte_q    <= {byte_q[6:0], 1'b0};
                bit_idx_q <= bit_idx_q + 3'd1;
            end
        end
    end

    assign bit_o = byte_q[7];

    // R11: a byte reload happens only once all eight bits of the current byte are out
    a_r11_byte_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !cap_i && bit_idx_q != 3'd7) |=> $stable(byte_idx_q));

    a_r11_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !cap_i && bit_idx_q == 3'd7) |=> (bit_idx_q == 3'd0));

endmodule

// File: rtl/dfs_ctrl.sv
module dfs_ctrl
    import dfs_pkg::*;
#(
    parameter int DIV       = 4,
    parameter int SETUP_CYC = 20,
    parameter int GAP_CYC   = 4000000,
    parameter int EXACT_LEN = 36,
    parameter int PAD_LEN   = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mode_i,
    input  logic bit_i,
    output logic cap_o,
    output logic adv_o,
    output logic busy_o,
    output logic en_n_o,
    output logic sclk_o,
    output logic sdat_o
);
    localparam int MAXC = dfs_max3(DIV, SETUP_CYC, GAP_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam int BW   = $clog2(PAD_LEN + 1);

    dfs_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic [BW-1:0] bit_q;
    dfs_mode_e     mode_q;
    logic          phase_end;
    logic          last_bit;

    always_comb begin
        unique case (state_q)
            ST_SETUP: lim = CW'(SETUP_CYC - 1);
            ST_LOW:   lim = CW'(DIV - 1);
            ST_HIGH:  lim = CW'(DIV - 1);
            ST_GAP:   lim = CW'(GAP_CYC - 1);
            default:  lim = '0;
        endcase
    end

    assign phase_end = (cnt_q == lim);
    assign last_bit  = (mode_q == MODE_PADDED) ? (bit_q == BW'(PAD_LEN - 1))
                                               : (bit_q == BW'(EXACT_LEN - 1));
    assign cap_o = (state_q == ST_IDLE) && start_i;
    assign adv_o = (state_q == ST_HIGH) && phase_end && !last_bit;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)   state_d = ST_SETUP;
            ST_SETUP: if (phase_end) state_d = ST_LOW;
            ST_LOW:   if (phase_end) state_d = ST_HIGH;
            ST_HIGH:  if (phase_end) state_d = last_bit ? ST_GAP : ST_LOW;
            ST_GAP:   if (phase_end) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register and phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            mode_q  <= MODE_EXACT;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q == ST_IDLE) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (cap_o) begin
                bit_q  <= '0;
                mode_q <= dfs_mode_e'(mode_i);
            end else if (adv_o) begin
                bit_q <= bit_q + BW'(1);
            end
        end
    end

    // output decode
    always_comb begin
        busy_o = 1'b1;
        en_n_o = 1'b1;
        sclk_o = 1'b0;
        sdat_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_SETUP: en_n_o = 1'b0;
            ST_LOW: begin
                en_n_o = 1'b0;
                sdat_o = bit_i;
            end
            ST_HIGH: begin
                en_n_o = 1'b0;
                sclk_o = 1'b1;
                sdat_o = bit_i;
            end
            ST_GAP:   en_n_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    // R10: data line quiet while the display is disabled
    a_r10_idle_data_low: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_o |-> !sdat_o);

    // R6: no clock while enable is high
    a_r6_clk_gated: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_o |-> !sclk_o);

    // R7: data holds while the clock is high
    a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdat_o));

    // R8: busy only rises in response to a strobe
    a_r8_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R5: enable falls with the clock low and the bit counter at the start bit
    a_r5_enable_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_n_o) |-> (!sclk_o && bit_q == '0));

    // R9: a strobe during a frame does not rewind the bit counter
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q == ST_LOW) |=> $stable(bit_q));

endmodule

// File: rtl/dfs_top.sv
module dfs_top #(
    parameter int PAY_W     = 34,
    parameter int DIV       = 4,
    parameter int SETUP_CYC = 20,
    parameter int GAP_CYC   = 4000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [PAY_W-1:0] image,
    output logic             busy,
    output logic             disp_en_n,
    output logic             ser_clk,
    output logic             ser_dat
);
    localparam int EXACT_LEN   = PAY_W + 2;
    localparam int FRAME_BYTES = (EXACT_LEN + 7) / 8;
    localparam int PAD_LEN     = FRAME_BYTES * 8;

    logic [PAD_LEN-1:0] frame;
    logic               cap;
    logic               adv;
    logic               cur_bit;

    dfs_frame_build #(
        .PAY_W   (PAY_W),
        .FRAME_W (PAD_LEN)
    ) u_build (
        .image_i (image),
        .frame_o (frame)
    );

    dfs_byte_shifter #(
        .FRAME_BYTES (FRAME_BYTES)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap),
        .adv_i   (adv),
        .frame_i (frame),
        .bit_o   (cur_bit)
    );

    dfs_ctrl #(
        .DIV       (DIV),
        .SETUP_CYC (SETUP_CYC),
        .GAP_CYC   (GAP_CYC),
        .EXACT_LEN (EXACT_LEN),
        .PAD_LEN   (PAD_LEN)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .mode_i  (mode),
        .bit_i   (cur_bit),
        .cap_o   (cap),
        .adv_o   (adv),
        .busy_o  (busy),
        .en_n_o  (disp_en_n),
        .sclk_o  (ser_clk),
        .sdat_o  (ser_dat)
    );

endmodule

// File: tb/dfs_top_bench.sv
`timescale 1ns/1ps
module dfs_top_bench;
    localparam int PAY_W = 34;
    localparam int DIV   = 2;
    localparam int SETUP = 20;
    localparam int GAP   = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             mode = 1'b0;
    logic [PAY_W-1:0] image = '0;
    logic             busy, disp_en_n, ser_clk, ser_dat;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dfs_top #(.PAY_W(PAY_W), .DIV(DIV), .SETUP_CYC(SETUP), .GAP_CYC(GAP)) u_dfs_top (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .image(image),
        .busy(busy), .disp_en_n(disp_en_n), .ser_clk(ser_clk), .ser_dat(ser_dat)
    );

    // monitor state, sampled at the falling edge
    logic bits [0:63];
    int   nb, rises, falls, pre_cyc, gap_cyc, r6_err, r7_err, r10_err, hi_run, lo_run;
    logic prev_clk, prev_dat;

    task automatic mon_clear();
        nb = 0; rises = 0; falls = 0; pre_cyc = 0; gap_cyc = 0;
        r6_err = 0; r7_err = 0; r10_err = 0; hi_run = 0; lo_run = 0;
    endtask

    initial begin
        mon_clear();
        prev_clk = 1'b0;
        prev_dat = 1'b0;
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (ser_clk && !prev_clk) begin
                if (nb < 64) bits[nb] = ser_dat;
                nb++;
                rises++;
                if (ser_dat !== prev_dat) r7_err++;
                if (lo_run < DIV) r6_err++;
                hi_run = 0;
            end
            if (!ser_clk && prev_clk) begin
                falls++;
                if (hi_run != DIV) r6_err++;
                lo_run = 0;
            end
            if (ser_clk) hi_run++; else lo_run++;
            if (ser_clk && ser_dat !== prev_dat) r7_err++;
            if (disp_en_n && (ser_dat || ser_clk)) r10_err++;
            if (!disp_en_n && rises == 0) pre_cyc++;
            if (disp_en_n && busy && rises > 0) gap_cyc++;
            prev_clk = ser_clk;
            prev_dat = ser_dat;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [PAY_W-1:0] img, input int k);
        if (k == 0) return 1'b1;
        if (k <= PAY_W) return img[k-1];
        return 1'b0;
    endfunction

    function automatic int exp_len(input logic m);
        return m ? 40 : 36;
    endfunction

    task automatic run_frame(input logic [PAY_W-1:0] img, input logic m, input bit inject);
        int  bad;
        int  first_bad;
        int  wait_n;
        bit  timeout;
        mon_clear();
        @(negedge clk);
        image = img; mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R8 busy after strobe", busy, 1);
        if (inject) begin
            // R9/R12: strobe again with a different image and mode while busy
            wait_n = 1 + int'($urandom_range(0, 150));
            repeat (wait_n) @(negedge clk);
            image = ~img; mode = ~m;
            if (busy) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        timeout = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy) begin timeout = 1'b0; break; end
        end
        check(!timeout, "R8 busy falls", int'(timeout), 0);
        check(rises == exp_len(m), m ? "R3 bit count" : "R2 bit count", rises, exp_len(m));
        check(falls == rises, "R6 clock ends low", falls, rises);
        bad = 0; first_bad = -1;
        for (int k = 0; k < exp_len(m) && k < nb; k++) begin
            if (bits[k] !== exp_bit(img, k)) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        end
        // R4/R11: order and byte boundaries are covered by the bit-by-bit stream compare
        check(bad == 0, m ? "R3 R4 R11 R12 stream" : "R2 R4 R12 stream", first_bad, -1);
        check(pre_cyc >= SETUP, "R5 enable setup", pre_cyc, SETUP);
        check(gap_cyc == GAP, "R8 gap length", gap_cyc, GAP);
        check(r6_err == 0, "R6 clock widths", r6_err, 0);
        check(r7_err == 0, "R7 data stability", r7_err, 0);
        check(r10_err == 0, "R10 idle data low", r10_err, 0);
        repeat (5) @(negedge clk);
        check(disp_en_n === 1'b1 && busy === 1'b0, "R9 no second frame", int'(disp_en_n), 1);
    endtask

    initial begin
        logic [PAY_W-1:0] img;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: reset values
        check(disp_en_n === 1'b1, "R1 enable high", disp_en_n, 1);
        check(ser_clk === 1'b0, "R1 clock low", ser_clk, 0);
        check(ser_dat === 1'b0, "R1 data low", ser_dat, 0);
        check(busy === 1'b0, "R1 busy low", busy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // directed corners
        run_frame('0, 1'b0, 1'b0);
        run_frame('1, 1'b0, 1'b0);
        run_frame('0, 1'b1, 1'b0);
        run_frame('1, 1'b1, 1'b0);
        run_frame(34'h0_0000_0080, 1'b1, 1'b0); // R4 decimal point of digit 1 into byte 1
        run_frame(34'h2_0000_0001, 1'b0, 1'b0);

        // random frames, some with an interfering strobe
        for (int n = 0; n < 24; n++) begin
            img = {$urandom(), $urandom()};
            run_frame(img, 1'($urandom_range(0, 1)), (n % 2) == 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule